// File: doc/BRIEF.md
# Fractional Oversampling Baud Tick Generator

This block produces the timing strobes for a serial port from the system clock. Software writes one packed divisor word that holds a 12-bit mantissa M and a 4-bit exponent N. The block then emits a single-cycle oversampling strobe at sixteen times the bit rate and a single-cycle bit strobe at the bit rate. The bit rate is f_clk * M / 2^(15+N), so fine rate steps are possible without a wide integer divider.

Timing comes from a phase accumulator, not from a down-counter. On every clock the mantissa is added to the accumulator. When the sum reaches 2^(11+N), an oversampling strobe is issued, and the remainder is kept so that the fractional rate is exact over time. A divide-by-sixteen counter on the oversampling strobes yields the bit strobe. A divisor write restarts both stages from zero, so no partial or doubled strobe mixes the old and new rates. Choosing M and N for a target rate is left to software.

Top module: `baud_frac_gen`

## Requirements
- R1: During and after a synchronous active-low reset both strobes are low, and the stored divisor is zero, so no strobe appears until a divisor write.
- R2: The divisor word places the exponent N in bits 15:12 and the mantissa M in bits 11:0. A write with N=2 and M=1536 gives its first oversampling strobe on the sixth clock edge after the write edge.
- R3: The accumulator starts at zero and adds M on each clock edge. A strobe is registered on every edge where the sum reaches 2^(11+N), and the excess is kept, so the strobe pattern matches exact fractional accumulation for any M and N.
- R4: The bit strobe is high only together with an oversampling strobe, and only on every sixteenth oversampling strobe, counted from the last write or reset.
- R5: The clock edge that takes a divisor write produces no strobe on either output. It restarts the accumulator and the sixteen-count at zero, and the new divisor applies from the following edge.
- R6: With M equal to 0, neither strobe is ever produced.
- R7: A mantissa field above 2047 is treated as 2047.
- R8: With M=1024 and N=0 the bit strobe repeats exactly every 32 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_wr | input | 1 | One-cycle strobe that loads div_word |
| div_word | input | 16 | Packed divisor: exponent in 15:12, mantissa in 11:0 |
| os_tick | output | 1 | Oversampling strobe, sixteen per bit period |
| bit_tick | output | 1 | Bit-rate strobe |

## Verification
The checks assume that div_wr is a clean synchronous strobe and that reset is held low for at least one edge before any write. The checks also assume that software only reads the strobes and never relies on the value of a mantissa above 2047. The stimulus drives every input half a period away from the active edge. It sends random divisor words with exponents held small, so that strobes actually occur within each window. It places writes at random gaps, including back-to-back writes and writes that land on a strobe edge. Directed cases add a zero mantissa, an out-of-range mantissa and the fixed rate of R8.

// File: rtl/baud_frac_pkg.sv
// Package: shared widths and the packed divisor layout for the
// fractional baud tick generator.
// Assumes: one exponent field above one mantissa field in a 16-bit word.
package baud_frac_pkg;

    localparam int MANT_W   = 12;   // mantissa field width
    localparam int EXP_W    = 4;    // exponent field width
    localparam int MANT_MAX = 2047; // largest mantissa honoured
    localparam int OVS      = 16;   // oversampling strobes per bit

    // Field order matters: the exponent sits above the mantissa.
    typedef struct packed {
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } div_word_t;

endpackage

// File: rtl/baud_frac_div_reg.sv
// Module: holding register for the divisor pair.
// Loads the exponent and a clamped mantissa on a write strobe.
// Assumes: wr_en is synchronous to clk and lasts one cycle per write.
module baud_frac_div_reg #(
    parameter int MANT_W   = baud_frac_pkg::MANT_W,
    parameter int EXP_W    = baud_frac_pkg::EXP_W,
    parameter int MANT_MAX = baud_frac_pkg::MANT_MAX
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [MANT_W+EXP_W-1:0]   wr_word,
    output logic [MANT_W-1:0]         mant_q,
    output logic [EXP_W-1:0]          exp_q
);

    localparam logic [MANT_W-1:0] MANT_LIM = MANT_W'(MANT_MAX);

    logic [MANT_W-1:0] mant_in;
    logic [EXP_W-1:0]  exp_in;
    logic [MANT_W-1:0] mant_clip;

    // Split the packed word into its two fields.
    always_comb begin
        mant_in = wr_word[MANT_W-1:0];
        exp_in  = wr_word[MANT_W+EXP_W-1:MANT_W];
    end

    // Limit the mantissa to the largest usable value.
    always_comb begin
        mant_clip = (mant_in > MANT_LIM) ? MANT_LIM : mant_in;
    end

    // Hold the divisor pair; reset leaves it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mant_q <= '0;
            exp_q  <= '0;
        end else if (wr_en) begin
            mant_q <= mant_clip;
            exp_q  <= exp_in;
        end
    end

endmodule

// File: rtl/baud_frac_phase_acc.sv
// Module: phase accumulator that makes the oversampling strobe.
// Adds the mantissa each clock. When the sum reaches 2^(MANT_W-1+expo),
// it raises a carry and keeps the remainder.
// Assumes: mant < 2^(MANT_W-1), which the divisor register guarantees.
module baud_frac_phase_acc #(
    parameter int MANT_W = baud_frac_pkg::MANT_W,
    parameter int EXP_W  = baud_frac_pkg::EXP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  expo,
    output logic              carry_c,
    output logic              tick_q
);

    localparam int BASE  = MANT_W - 1;           // carry bit when expo is 0
    localparam int ACC_W = BASE + (1 << EXP_W);  // covers the top carry bit
    localparam int IDX_W = $clog2(ACC_W);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] keep_mask;
    logic [IDX_W-1:0] carry_idx;

    // Select the bit that marks one full phase turn.
    always_comb begin
        carry_idx = IDX_W'(BASE) + IDX_W'(expo);
    end

    // Build the mask of bits below the carry bit.
    always_comb begin
        for (int i = 0; i < ACC_W; i++) begin
            keep_mask[i] = (i < int'(carry_idx));
        end
    end

    // Advance the phase by the mantissa and detect a full turn.
    always_comb begin
        sum     = acc_q + ACC_W'(mant);
        carry_c = sum[carry_idx] && !clr;
    end

    // Store the remainder and register the strobe; a clear restarts the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= sum & keep_mask;
            tick_q <= carry_c;
        end
    end

endmodule

// File: rtl/baud_frac_tick_div.sv
// Module: divides the oversampling carry by OVS to make the bit strobe.
// Its output is registered on the same edge as the oversampling strobe.
// Assumes: in_pulse is already forced low while clr is high.
module baud_frac_tick_div #(
    parameter int OVS = baud_frac_pkg::OVS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_pulse,
    output logic out_q
);

    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // Detect the pulse that completes one group of OVS.
    always_comb begin
        wrap = in_pulse && (cnt_q == LAST);
    end

    // Count incoming pulses and emit a strobe on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            out_q <= wrap;
            if (in_pulse) begin
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/baud_frac_gen.sv
// Module: fractional exponent/mantissa baud tick generator (top).
// Turns a packed divisor word into an oversampling strobe and a bit strobe.
// A write restarts the phase and the divide-by-OVS stage.
// Assumes: div_wr is a synchronous one-cycle strobe.
module baud_frac_gen #(
    parameter int MANT_W   = baud_frac_pkg::MANT_W,
    parameter int EXP_W    = baud_frac_pkg::EXP_W,
    parameter int MANT_MAX = baud_frac_pkg::MANT_MAX,
    parameter int OVS      = baud_frac_pkg::OVS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    div_wr,
    input  logic [MANT_W+EXP_W-1:0] div_word,
    output logic                    os_tick,
    output logic                    bit_tick
);

    logic [MANT_W-1:0] mant_q;
    logic [EXP_W-1:0]  exp_q;
    logic              carry_c;

    baud_frac_div_reg #(
        .MANT_W   (MANT_W),
        .EXP_W    (EXP_W),
        .MANT_MAX (MANT_MAX)
    ) u_div_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (div_wr),
        .wr_word (div_word),
        .mant_q  (mant_q),
        .exp_q   (exp_q)
    );

    baud_frac_phase_acc #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (div_wr),
        .mant    (mant_q),
        .expo    (exp_q),
        .carry_c (carry_c),
        .tick_q  (os_tick)
    );

    baud_frac_tick_div #(
        .OVS (OVS)
    ) u_bitdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (div_wr),
        .in_pulse (carry_c),
        .out_q    (bit_tick)
    );

endmodule

// File: rtl/baud_frac_gen_chk.sv
// Module: assertion checker bound to baud_frac_gen.
// Keeps its own count of oversampling strobes since the last restart.
// Assumes: reset is held low for at least one edge at start-up.
module baud_frac_gen_chk #(
    parameter int MANT_W   = baud_frac_pkg::MANT_W,
    parameter int MANT_MAX = baud_frac_pkg::MANT_MAX,
    parameter int OVS      = baud_frac_pkg::OVS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_wr,
    input logic [MANT_W-1:0] mant_q,
    input logic              os_tick,
    input logic              bit_tick
);

    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;

    logic [CNT_W-1:0] seen_q;

    // Count observed oversampling strobes modulo OVS since reset or write.
    always_ff @(posedge clk) begin
        if (!rst_n || div_wr) begin
            seen_q <= '0;
        end else if (os_tick) begin
            seen_q <= (seen_q == CNT_W'(OVS - 1)) ? '0 : seen_q + 1'b1;
        end
    end

    // R4: a bit strobe never appears alone
    a_r4_bit_needs_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R4: the bit strobe marks exactly every sixteenth oversampling strobe
    a_r4_every_sixteenth: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> (bit_tick == (seen_q == CNT_W'(OVS - 1))));

    // R5: the write edge leaves both strobes low
    a_r5_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (!os_tick && !bit_tick));

    // R6: a zero mantissa gives no strobe
    a_r6_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mant_q == '0) |=> !os_tick);

    // R7: the stored mantissa never exceeds the usable limit
    a_r7_mant_limit: assert property (@(posedge clk) disable iff (!rst_n)
        mant_q <= MANT_W'(MANT_MAX));

endmodule

bind baud_frac_gen baud_frac_gen_chk #(
    .MANT_W   (MANT_W),
    .MANT_MAX (MANT_MAX),
    .OVS      (OVS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_wr   (div_wr),
    .mant_q   (mant_q),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
);

// File: tb/baud_frac_gen_bench.sv
module baud_frac_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_wr = 1'b0;
    logic [15:0] div_word = '0;
    logic        os_tick;
    logic        bit_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state after the upcoming edge
    longint m_acc = 0;
    int     m_mant = 0, m_exp = 0, m_cnt = 0;
    bit     exp_os = 1'b0, exp_bit = 1'b0;
    bit     obs_os, obs_bit;
    string  cur_req = "R1";
    int     cyc = 0;

    always #2 clk = ~clk;

    baud_frac_gen u_baud_frac_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_wr   (div_wr),
        .div_word (div_word),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    function automatic int clip_mant(input int m);
        return (m > 2047) ? 2047 : m;
    endfunction

    task automatic check(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // advance the model by one edge using the inputs now driven
    task automatic model_edge();
        longint sum, modv;
        if (!rst_n) begin
            m_acc = 0; m_mant = 0; m_exp = 0; m_cnt = 0; exp_os = 0; exp_bit = 0;
        end else if (div_wr) begin
            m_mant = clip_mant(int'(div_word[11:0]));
            m_exp  = int'(div_word[15:12]);
            m_acc = 0; m_cnt = 0; exp_os = 0; exp_bit = 0;
        end else begin
            sum  = m_acc + longint'(m_mant);
            modv = longint'(1) << (11 + m_exp);
            exp_os  = (sum >= modv);
            exp_bit = exp_os && (m_cnt == 15);
            m_acc   = exp_os ? sum - modv : sum;
            if (exp_os) m_cnt = (m_cnt + 1) % 16;
        end
    endtask

    // one cycle: check outputs away from the edge, then drive the next inputs
    task automatic step(input bit r, input bit w, input logic [15:0] word);
        @(negedge clk);
        cyc++;
        obs_os  = os_tick;
        obs_bit = bit_tick;
        check(cur_req, "os_tick", int'(obs_os), int'(exp_os));
        check(cur_req, "bit_tick", int'(obs_bit), int'(exp_bit));
        rst_n    = r;
        div_wr   = w;
        div_word = word;
        model_edge();
    endtask

    initial begin
        int first, last_bit, gap_bad, n_os;
        void'($urandom(32'd20240611));
        model_edge();

        // R1: reset and idle with a zero divisor
        cur_req = "R1";
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 16'h0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 16'h0);

        // R6: zero mantissa with a nonzero exponent
        cur_req = "R6";
        step(1'b1, 1'b1, 16'h3000);
        n_os = 0;
        for (int i = 0; i < 60; i++) begin
            step(1'b1, 1'b0, 16'h0);
            if (obs_os || obs_bit) n_os++;
        end
        check("R6", "strobes with zero mantissa", n_os, 0);

        // R2: field layout, first strobe timing for N=2, M=1536
        cur_req = "R2";
        step(1'b1, 1'b1, {4'd2, 12'd1536});
        first = -1;
        for (int c = 1; c <= 20; c++) begin
            step(1'b1, 1'b0, 16'h0);
            if (obs_os && first < 0) first = c - 1;
        end
        check("R2", "edges from write to first strobe", first, 6);

        // R8: fixed rate, bit strobe every 32 cycles
        cur_req = "R8";
        step(1'b1, 1'b1, {4'd0, 12'd1024});
        last_bit = -1; gap_bad = 0;
        for (int c = 0; c < 400; c++) begin
            step(1'b1, 1'b0, 16'h0);
            if (obs_bit) begin
                if (last_bit >= 0 && (cyc - last_bit) != 32) gap_bad++;
                last_bit = cyc;
            end
        end
        check("R8", "bit strobe gaps not equal to 32", gap_bad, 0);

        // R7: out-of-range mantissa behaves as 2047 (compare strobe counts)
        cur_req = "R7";
        step(1'b1, 1'b1, {4'd0, 12'd4095});
        n_os = 0;
        for (int c = 0; c < 2048; c++) begin
            step(1'b1, 1'b0, 16'h0);
            if (obs_os) n_os++;
        end
        check("R7", "strobes in 2048 cycles at clamped mantissa", n_os, 2046);

        // R5: write landing on a busy stream, and back-to-back writes
        cur_req = "R5";
        for (int c = 0; c < 37; c++) step(1'b1, 1'b0, 16'h0);
        step(1'b1, 1'b1, {4'd1, 12'd700});
        step(1'b1, 1'b1, {4'd0, 12'd2047});
        for (int c = 0; c < 100; c++) step(1'b1, 1'b0, 16'h0);

        // R3, R4: random divisors and random write gaps
        cur_req = "R3/R4";
        for (int k = 0; k < 60; k++) begin
            logic [15:0] w;
            int gap;
            w[15:12] = 4'($urandom_range(0, 3));
            w[11:0]  = 12'($urandom_range(0, 4095));
            gap = $urandom_range(0, 600);
            step(1'b1, 1'b1, w);
            for (int c = 0; c < gap; c++) step(1'b1, 1'b0, 16'h0);
        end

        // R1: reset in the middle of a running stream
        cur_req = "R1";
        step(1'b0, 1'b0, 16'h0);
        for (int c = 0; c < 50; c++) step(1'b1, 1'b0, 16'h0);
        check("R1", "stored mantissa zero after reset (strobe count)", int'(os_tick), 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule